// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames on a single input line. A free-running divider produces a tick at sixteen times the bit rate. The receiver hunts for a low level on the idle line and confirms it half a bit later. It then shifts in 7 or 8 data bits, least significant bit first, followed by an optional parity bit and one or two stop bits. At the end of the frame it checks the frame and updates a holding register, a data-full flag and three sticky error flags.

The outcome depends on which check fails. If the data-full flag is still set when a frame ends, the frame is an overrun: the holding register keeps its old contents. A parity or framing fault still writes the new byte into the holding register, but leaves the data-full flag clear. A clean frame writes the byte and sets the data-full flag. While any error flag is set, the receiver does not look for new start bits.

Software clears the data-full flag with one pulse input and the error flags with another. A single enable gates both the receive-full and receive-error interrupt requests.

Top module: `serial_rx_core`

## Requirements
- R1: A start is accepted only if the synchronised line is still low 8 ticks after the first low sample. If the line is high by then, the event is dropped and the receiver returns to hunting with no flag changed.
- R2: Data bits arrive least significant first. In 7-bit mode (`cfg_bits7`=1) the byte appears in `rx_data[6:0]` and `rx_data[7]` reads 0.
- R3: With parity enabled, a parity fault is flagged when the data bits plus the parity bit hold an odd count of ones (`cfg_par_odd`=0) or an even count of ones (`cfg_par_odd`=1). With parity disabled, no parity bit is expected and `err_par` is never set.
- R4: A stop bit sampled as 0 sets `err_frm`. With `cfg_stop2`=1 only the first stop bit is examined, so a 0 in the second stop bit leaves every flag unchanged.
- R5: If `rx_full` is 1 when a frame ends, `err_ovr` is set, `rx_data` keeps its previous value and `rx_full` stays 1.
- R6: If a frame has a parity or framing fault and `rx_full` is 0, the byte is written to `rx_data`, the matching flag is set and `rx_full` stays 0.
- R7: If a frame passes every check, the byte is written to `rx_data` and `rx_full` is set.
- R8: While any error flag is 1, no new frame is received, even if `rx_full` is cleared.
- R9: A one-cycle pulse on `rd_clr` clears `rx_full` at the next edge, and a pulse on `err_clr` clears all three error flags at the next edge, unless a frame ends in that same cycle.
- R10: `irq_rx` equals `irq_en` AND `rx_full`, and `irq_err` equals `irq_en` AND the OR of the error flags. Both are registered and track the flags in the same cycle.
- R11: One bit lasts 16*(`cfg_div`+1) clock cycles.
- R12: After reset, `rx_data` is 0 and all flags and interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial line, idles high |
| cfg_div | input | DIV_W | Tick divider; tick period is cfg_div+1 clocks |
| cfg_bits7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| irq_en | input | 1 | Enable for both interrupt requests |
| rd_clr | input | 1 | Pulse to clear the data-full flag |
| err_clr | input | 1 | Pulse to clear the error flags |
| rx_data | output | DW | Holding register |
| rx_full | output | 1 | Data-full flag |
| err_ovr | output | 1 | Overrun flag |
| err_frm | output | 1 | Framing error flag |
| err_par | output | 1 | Parity error flag |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
The assertions assume that the configuration inputs stay constant while a frame is in flight and that the clear pulses last exactly one cycle. The interrupt checks also assume `irq_en` changes only at clock edges. The bench changes the configuration only while the line is idle, between frames, and after the previous frame has finished. It drives every input on the falling edge, so all changes fall between active edges. Every frame is followed by at least two idle bit times, which keeps frame ends well separated from the clear pulses.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int OVS = 16;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_baud.sv
module rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= div) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          hunt_en,
  input  logic          cfg_bits7,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_stop2,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          par_bad,
  output logic          stop_bad,
  output logic          busy
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e     st_q;
  logic [CW-1:0] ocnt_q;
  logic [BW-1:0] bidx_q;
  logic [DW-1:0] sh_q;
  logic          pbit_q;
  logic [BW-1:0] nbits;
  logic [DW-1:0] algn;

  assign nbits = cfg_bits7 ? BW'(DW - 1) : BW'(DW);
  assign algn  = cfg_bits7 ? {1'b0, sh_q[DW-1:1]} : sh_q;
  assign busy  = (st_q != ST_HUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_HUNT;
      ocnt_q   <= '0;
      bidx_q   <= '0;
      sh_q     <= '0;
      pbit_q   <= 1'b0;
      done     <= 1'b0;
      data     <= '0;
      par_bad  <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st_q)
          ST_HUNT: begin
            if (hunt_en && !rxd) begin
              st_q   <= ST_START;
              ocnt_q <= '0;
            end
          end
          ST_START: begin
            if (ocnt_q == MID) begin
              ocnt_q <= '0;
              bidx_q <= '0;
              st_q   <= rxd ? ST_HUNT : ST_DATA;
            end else begin
              ocnt_q <= ocnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (ocnt_q == LAST) begin
              ocnt_q <= '0;
              sh_q   <= {rxd, sh_q[DW-1:1]};
              bidx_q <= bidx_q + 1'b1;
              if (bidx_q == nbits - 1'b1)
                st_q <= cfg_par_en ? ST_PAR : ST_STOP;
            end else begin
              ocnt_q <= ocnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (ocnt_q == LAST) begin
              ocnt_q <= '0;
              pbit_q <= rxd;
              st_q   <= ST_STOP;
            end else begin
              ocnt_q <= ocnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (ocnt_q == LAST) begin
              ocnt_q   <= '0;
              done     <= 1'b1;
              data     <= algn;
              par_bad  <= cfg_par_en & (^algn ^ pbit_q ^ cfg_par_odd);
              stop_bad <= ~rxd;
              st_q     <= ST_HOLD;
            end else begin
              ocnt_q <= ocnt_q + 1'b1;
            end
          end
          ST_HOLD: begin
            // second stop bit is timed but never inspected; wait for a high line
            if (cfg_stop2 && ocnt_q != LAST) ocnt_q <= ocnt_q + 1'b1;
            else if (rxd)                    st_q   <= ST_HUNT;
          end
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DW    = 8,
  parameter int DIV_W = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_in,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_bits7,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_stop2,
  input  logic             irq_en,
  input  logic             rd_clr,
  input  logic             err_clr,
  output logic [DW-1:0]    rx_data,
  output logic             rx_full,
  output logic             err_ovr,
  output logic             err_frm,
  output logic             err_par,
  output logic             irq_rx,
  output logic             irq_err
);
  logic          rxd;
  logic          tick;
  logic          fr_done;
  logic [DW-1:0] fr_data;
  logic          fr_pbad;
  logic          fr_sbad;
  logic          fr_busy;
  logic          err_any;

  logic [DW-1:0] data_d;
  logic          full_d, ovr_d, frm_d, par_d;

  assign err_any = err_ovr | err_frm | err_par;

  rx_sync #(.STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_in),
    .dout(rxd)
  );

  rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk (clk),
    .rst (rst),
    .div (cfg_div),
    .tick(tick)
  );

  rx_frame #(.DW(DW)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .rxd        (rxd),
    .hunt_en    (~err_any),
    .cfg_bits7  (cfg_bits7),
    .cfg_par_en (cfg_par_en),
    .cfg_par_odd(cfg_par_odd),
    .cfg_stop2  (cfg_stop2),
    .done       (fr_done),
    .data       (fr_data),
    .par_bad    (fr_pbad),
    .stop_bad   (fr_sbad),
    .busy       (fr_busy)
  );

  always_comb begin
    data_d = rx_data;
    full_d = rx_full;
    ovr_d  = err_ovr;
    frm_d  = err_frm;
    par_d  = err_par;
    if (rd_clr) full_d = 1'b0;
    if (err_clr) begin
      ovr_d = 1'b0;
      frm_d = 1'b0;
      par_d = 1'b0;
    end
    if (fr_done) begin
      if (rx_full) begin
        ovr_d = 1'b1;
      end else begin
        data_d = fr_data;
        if (fr_pbad || fr_sbad) begin
          par_d = par_d | fr_pbad;
          frm_d = frm_d | fr_sbad;
        end else begin
          full_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      err_ovr <= 1'b0;
      err_frm <= 1'b0;
      err_par <= 1'b0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      rx_data <= data_d;
      rx_full <= full_d;
      err_ovr <= ovr_d;
      err_frm <= frm_d;
      err_par <= par_d;
      irq_rx  <= irq_en & full_d;
      irq_err <= irq_en & (ovr_d | frm_d | par_d);
    end
  end
endmodule

// File: rtl/serial_rx_checks.sv
module serial_rx_checks #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_clr,
  input logic          err_clr,
  input logic          irq_en,
  input logic [DW-1:0] rx_data,
  input logic          rx_full,
  input logic          err_ovr,
  input logic          err_frm,
  input logic          err_par,
  input logic          irq_rx,
  input logic          irq_err,
  input logic          fr_done,
  input logic          fr_busy
);
  logic errs;
  assign errs = err_ovr | err_frm | err_par;

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_clr && !fr_done |=> !rx_full); // R9
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    err_clr && !fr_done |=> !errs); // R9
  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    fr_done && rx_full |=> err_ovr && rx_full && $stable(rx_data)); // R5
  AST_FULL_FROM_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(fr_done)); // R7
  AST_NO_HUNT_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    errs && !fr_busy |=> !fr_busy); // R8
  AST_IRQ_RX: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_rx == ($past(irq_en) && rx_full)); // R10
  AST_IRQ_ERR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_err == ($past(irq_en) && errs)); // R10
endmodule

bind serial_rx_core serial_rx_checks #(.DW(DW)) u_checks (
  .clk    (clk),
  .rst    (rst),
  .rd_clr (rd_clr),
  .err_clr(err_clr),
  .irq_en (irq_en),
  .rx_data(rx_data),
  .rx_full(rx_full),
  .err_ovr(err_ovr),
  .err_frm(err_frm),
  .err_par(err_par),
  .irq_rx (irq_rx),
  .irq_err(irq_err),
  .fr_done(fr_done),
  .fr_busy(fr_busy)
);

// File: tb/tb_serial_rx_core.sv
module tb_serial_rx_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_in = 1'b1;
  logic [15:0] cfg_div = '0;
  logic        cfg_bits7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic        irq_en = 1'b1, rd_clr = 1'b0, err_clr = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_full, err_ovr, err_frm, err_par, irq_rx, irq_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serial_rx_core dut (
    .clk(clk), .rst(rst), .rx_in(rx_in), .cfg_div(cfg_div),
    .cfg_bits7(cfg_bits7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .irq_en(irq_en), .rd_clr(rd_clr), .err_clr(err_clr),
    .rx_data(rx_data), .rx_full(rx_full), .err_ovr(err_ovr), .err_frm(err_frm),
    .err_par(err_par), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  typedef struct packed {
    logic       b7, pe, po, s2;
    logic [1:0] div;
    logic [7:0] d;
    logic       flip_par, stop_low;
    logic       x_full, x_frm, x_par;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 8'hD5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 8'h81, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h96, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h0F, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_bits(input int n);
    repeat (n * 16 * (int'(cfg_div) + 1)) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v);
    rx_in = v;
    repeat (16 * (int'(cfg_div) + 1)) @(negedge clk);
  endtask

  // R11: each bit is held for 16*(cfg_div+1) clocks
  task automatic send(input logic [7:0] d, input logic flip_par,
                      input logic stop1, input logic stop2v);
    logic par;
    int nb;
    nb  = cfg_bits7 ? 7 : 8;
    par = cfg_par_odd;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      drive_bit(d[i]);
      par = par ^ d[i];
    end
    if (cfg_par_en) drive_bit(par ^ flip_par);
    drive_bit(stop1);
    if (cfg_stop2) drive_bit(stop2v);
    rx_in = 1'b1;
    idle_bits(2);
  endtask

  task automatic pulse(input logic rd, input logic er);
    rd_clr  = rd;
    err_clr = er;
    @(negedge clk);
    rd_clr  = 1'b0;
    err_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 data", int'(rx_data), 0);
    chk("R12 flags", int'({rx_full, err_ovr, err_frm, err_par, irq_rx, irq_err}), 0);

    // vector table: configuration, frame, expected flags
    foreach (VEC[i]) begin
      cfg_bits7   = VEC[i].b7;
      cfg_par_en  = VEC[i].pe;
      cfg_par_odd = VEC[i].po;
      cfg_stop2   = VEC[i].s2;
      cfg_div     = 16'(VEC[i].div);
      idle_bits(1);
      send(VEC[i].d, VEC[i].flip_par, ~VEC[i].stop_low, 1'b1);
      chk($sformatf("R2 R6 R7 data v%0d", i), int'(rx_data),
          int'(VEC[i].b7 ? (VEC[i].d & 8'h7F) : VEC[i].d));
      chk($sformatf("R7 full v%0d", i), int'(rx_full), int'(VEC[i].x_full));
      chk($sformatf("R4 frm v%0d", i), int'(err_frm), int'(VEC[i].x_frm));
      chk($sformatf("R3 par v%0d", i), int'(err_par), int'(VEC[i].x_par));
      chk($sformatf("R10 irq v%0d", i), int'({irq_rx, irq_err}),
          int'({VEC[i].x_full, VEC[i].x_frm | VEC[i].x_par}));
      pulse(1'b1, 1'b1);
      chk($sformatf("R9 cleared v%0d", i), int'({rx_full, err_ovr, err_frm, err_par}), 0);
    end

    // R4: second stop bit low is not examined
    cfg_bits7 = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop2 = 1'b1; cfg_div = 16'd0;
    send(8'h5A, 1'b0, 1'b1, 1'b0);
    chk("R4 stop2 ignored frm", int'(err_frm), 0);
    chk("R4 stop2 ignored full", int'({rx_full, rx_data}), int'({1'b1, 8'h5A}));
    pulse(1'b1, 1'b0);
    cfg_stop2 = 1'b0;

    // R1: short low glitch is dropped
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
    idle_bits(3);
    chk("R1 glitch flags", int'({rx_full, err_ovr, err_frm, err_par}), 0);
    chk("R1 glitch data", int'(rx_data), 8'h5A);
    send(8'hC3, 1'b0, 1'b1, 1'b1);
    chk("R1 after glitch", int'({rx_full, rx_data}), int'({1'b1, 8'hC3}));

    // R5: overrun keeps old data
    send(8'h22, 1'b0, 1'b1, 1'b1);
    chk("R5 ovr flag", int'(err_ovr), 1);
    chk("R5 ovr data", int'({rx_full, rx_data}), int'({1'b1, 8'hC3}));

    // R8: reception blocked while an error is pending
    pulse(1'b1, 1'b0);
    send(8'h33, 1'b0, 1'b1, 1'b1);
    chk("R8 blocked", int'({rx_full, err_ovr, rx_data}), int'({1'b0, 1'b1, 8'hC3}));
    pulse(1'b0, 1'b1);
    send(8'h44, 1'b0, 1'b1, 1'b1);
    chk("R8 resumed", int'({rx_full, err_ovr, rx_data}), int'({1'b1, 1'b0, 8'h44}));

    // R10: interrupts gated by enable
    irq_en = 1'b0;
    @(negedge clk);
    chk("R10 gated", int'({irq_rx, irq_err}), 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R10 enabled", int'({irq_rx, irq_err}), int'({1'b1, 1'b0}));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule